// File: doc/BRIEF.md
# Mesh Relaxation Array for Steady-State Heat Conduction

This block is a small two-dimensional mesh of identical processing elements that works out the steady-state temperature of a conducting plane. A ring of fixed cells sits around an interior grid of ROWS x COLS cells. The fixed cells hold the edge temperatures. The interior cells hold the current estimates. One hardwired controller broadcasts a single operation per cycle, and every element carries it out in that same cycle. Each element talks only to the four elements next to it. It receives its neighbours' values through broadcast moves: the whole mesh shifts one step in one direction per move.

Software loads every cell through the load port while the block is idle. It then pulses start with a tolerance. Each iteration, every interior cell replaces its value with the truncated mean of its four neighbours. Every cell also raises a local flag when its change was below the tolerance. The AND of all these flags ends the run. A maximum iteration count ends a run that does not settle, and a timeout flag marks that case. When the run is over, the read port returns any cell's value.

Top module: `mesh_relax`

## Requirements
- R1: After reset, busy, done and timeout are 0, iter_cnt is 0, and every cell reads as 0.
- R2: While idle, a cycle with ld_en=1 writes ld_data into the cell at (ld_row, ld_col). Row 0, row ROWS+1, column 0 and column COLS+1 form the fixed ring, and all other positions are interior. The read port returns the cell at (rd_row, rd_col) combinationally, and returns 0 for a position outside the grid.
- R3: In each iteration, every interior cell takes floor((N+S+E+W)/4) of its four neighbours' values from the previous iteration. The sum is formed without overflow on 16-bit unsigned values, and all cells commit together (Jacobi order).
- R4: Fixed ring cells never change during a run.
- R5: A run stops after the first iteration in which |new-old| < tol holds for every interior cell. done then rises and timeout stays 0. The tolerance is captured when start is accepted.
- R6: iter_cnt equals the number of iterations performed in the current run, including the last one.
- R7: If MAX_ITER iterations complete without convergence, done and timeout both rise, and iter_cnt equals MAX_ITER.
- R8: An iteration is the fixed sequence move-down, move-up, move-right, move-left, average, commit, evaluate, one cycle each. done rises exactly 7 x iter_cnt clock edges after the edge that accepts start.
- R9: While busy, ld_en and start have no effect: cell contents, the result and the timing are unchanged.
- R10: done and timeout hold until the next accepted start. One edge after start is accepted, busy is 1 and done, timeout and iter_cnt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a relaxation run (accepted when idle) |
| tol | input | 16 | Convergence tolerance, captured at start |
| ld_en | input | 1 | Write enable for a cell (idle only) |
| ld_row | input | $clog2(ROWS+2) | Row of the written cell |
| ld_col | input | $clog2(COLS+2) | Column of the written cell |
| ld_data | input | 16 | Value written |
| rd_row | input | $clog2(ROWS+2) | Row of the read cell |
| rd_col | input | $clog2(COLS+2) | Column of the read cell |
| rd_data | output | 16 | Value of the read cell |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished |
| timeout | output | 1 | Last run hit the iteration limit |
| iter_cnt | output | $clog2(MAX_ITER+1) | Iterations in the current or last run |

## Verification
The relaxation is driven with five edge and start patterns, and each run is compared cell by cell with a separate Jacobi model:
- A uniform plane converges in one iteration. It separates the evaluation from the commit.
- A single hot edge settles over many iterations. It exposes any order dependence, such as scan-order updates instead of simultaneous ones.
- Mixed edges with a ramped interior test the handling of truncation.
- Near-full-scale edges would fail if the four-value sum overflowed.
- A zero tolerance can never be met, so it forces the iteration limit.

Directed runs inject loads and a second start in the middle of an iteration, to show that neither reaches the mesh. They also confirm that done holds and then clears on a new start.

// File: rtl/mesh_pkg.sv
package mesh_pkg;

    localparam int DATA_W = 16;
    localparam int SUM_W  = DATA_W + 2;

    typedef logic [DATA_W-1:0] word_t;

    // Broadcast operations, in the order the controller issues them.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_MOVE_DOWN,   // every value steps south: each element captures its north neighbour
        OP_MOVE_UP,     // every value steps north: capture south neighbour
        OP_MOVE_RIGHT,  // every value steps east: capture west neighbour
        OP_MOVE_LEFT,   // every value steps west: capture east neighbour
        OP_AVG,         // form the mean and the local status bit
        OP_COMMIT,      // all elements adopt the new value together
        OP_EVAL         // controller inspects the combined status
    } op_e;

    // Local operand store of one element.
    typedef struct packed {
        word_t n;
        word_t s;
        word_t e;
        word_t w;
    } nbr_t;

    function automatic word_t avg4(nbr_t v);
        logic [SUM_W-1:0] sum;
        sum = SUM_W'(v.n) + SUM_W'(v.s) + SUM_W'(v.e) + SUM_W'(v.w);
        return sum[SUM_W-1:2];
    endfunction

    function automatic word_t absdiff(word_t a, word_t b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/mesh_pe.sv
module mesh_pe
    import mesh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  word_t in_n,
    input  word_t in_s,
    input  word_t in_e,
    input  word_t in_w,
    input  word_t tol,
    input  logic  ld_en,
    input  word_t ld_data,
    output word_t val,
    output logic  ok
);

    word_t val_q;
    word_t nxt_q;
    nbr_t  store_q;
    logic  ok_q;
    word_t mean;

    assign mean = avg4(store_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q   <= '0;
            nxt_q   <= '0;
            store_q <= '0;
            ok_q    <= 1'b0;
        end else begin
            case (op)
                OP_IDLE:       if (ld_en) val_q <= ld_data;
                OP_MOVE_DOWN:  store_q.n <= in_n;
                OP_MOVE_UP:    store_q.s <= in_s;
                OP_MOVE_RIGHT: store_q.w <= in_w;
                OP_MOVE_LEFT:  store_q.e <= in_e;
                OP_AVG: begin
                    nxt_q <= mean;
                    ok_q  <= (absdiff(mean, val_q) < tol);
                end
                OP_COMMIT:     val_q <= nxt_q;
                default: ;
            endcase
        end
    end

    assign val = val_q;
    assign ok  = ok_q;

endmodule

// File: rtl/mesh_ctrl.sv
module mesh_ctrl
    import mesh_pkg::*;
#(
    parameter int MAX_ITER = 255,
    parameter int IW       = $clog2(MAX_ITER + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          all_ok,
    output op_e           op,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [IW-1:0] iter_cnt
);

    op_e           op_q;
    logic          done_q;
    logic          to_q;
    logic [IW-1:0] iter_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            done_q <= 1'b0;
            to_q   <= 1'b0;
            iter_q <= '0;
        end else begin
            case (op_q)
                OP_IDLE: begin
                    if (start) begin
                        op_q   <= OP_MOVE_DOWN;
                        done_q <= 1'b0;
                        to_q   <= 1'b0;
                        iter_q <= '0;
                    end
                end
                OP_MOVE_DOWN:  op_q <= OP_MOVE_UP;
                OP_MOVE_UP:    op_q <= OP_MOVE_RIGHT;
                OP_MOVE_RIGHT: op_q <= OP_MOVE_LEFT;
                OP_MOVE_LEFT:  op_q <= OP_AVG;
                OP_AVG:        op_q <= OP_COMMIT;
                OP_COMMIT: begin
                    op_q   <= OP_EVAL;
                    iter_q <= iter_q + 1'b1;
                end
                OP_EVAL: begin
                    if (all_ok) begin
                        op_q   <= OP_IDLE;
                        done_q <= 1'b1;
                    end else if (iter_q == IW'(MAX_ITER)) begin
                        op_q   <= OP_IDLE;
                        done_q <= 1'b1;
                        to_q   <= 1'b1;
                    end else begin
                        op_q <= OP_MOVE_DOWN;
                    end
                end
                default: op_q <= OP_IDLE;
            endcase
        end
    end

    assign op       = op_q;
    assign busy     = (op_q != OP_IDLE);
    assign done     = done_q;
    assign timeout  = to_q;
    assign iter_cnt = iter_q;

endmodule

// File: rtl/mesh_relax.sv
module mesh_relax
    import mesh_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int MAX_ITER = 255,
    localparam int GR      = ROWS + 2,
    localparam int GC      = COLS + 2,
    localparam int RIW     = $clog2(GR),
    localparam int CIW     = $clog2(GC),
    localparam int IW      = $clog2(MAX_ITER + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tol,
    input  logic              ld_en,
    input  logic [RIW-1:0]    ld_row,
    input  logic [CIW-1:0]    ld_col,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [RIW-1:0]    rd_row,
    input  logic [CIW-1:0]    rd_col,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic              timeout,
    output logic [IW-1:0]     iter_cnt
);

    localparam int NCELL = GR * GC;
    localparam int NPE   = ROWS * COLS;

    op_e                     op_w;
    logic                    busy_w;
    logic                    ld_ok;
    logic                    start_ok;
    word_t                   tol_q;
    logic [NPE-1:0]          ok_bits;
    logic [NCELL*DATA_W-1:0] grid;

    assign ld_ok    = ld_en && !busy_w;
    assign start_ok = start && !busy_w;

    always_ff @(posedge clk) begin
        if (rst)           tol_q <= '0;
        else if (start_ok) tol_q <= tol;
    end

    mesh_ctrl #(.MAX_ITER(MAX_ITER), .IW(IW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .all_ok   (&ok_bits),
        .op       (op_w),
        .busy     (busy_w),
        .done     (done),
        .timeout  (timeout),
        .iter_cnt (iter_cnt)
    );

    assign busy = busy_w;

    for (genvar gr = 0; gr < GR; gr++) begin : g_row
        for (genvar gc = 0; gc < GC; gc++) begin : g_col
            logic hit;
            assign hit = ld_ok && (ld_row == RIW'(gr)) && (ld_col == CIW'(gc));
            if (gr == 0 || gr == GR - 1 || gc == 0 || gc == GC - 1) begin : g_ring
                word_t fixed_q;
                always_ff @(posedge clk) begin
                    if (rst)      fixed_q <= '0;
                    else if (hit) fixed_q <= ld_data;
                end
                assign grid[(gr*GC+gc)*DATA_W +: DATA_W] = fixed_q;
            end else begin : g_elem
                mesh_pe u_pe (
                    .clk     (clk),
                    .rst     (rst),
                    .op      (op_w),
                    .in_n    (grid[((gr-1)*GC+gc)*DATA_W +: DATA_W]),
                    .in_s    (grid[((gr+1)*GC+gc)*DATA_W +: DATA_W]),
                    .in_e    (grid[(gr*GC+gc+1)*DATA_W +: DATA_W]),
                    .in_w    (grid[(gr*GC+gc-1)*DATA_W +: DATA_W]),
                    .tol     (tol_q),
                    .ld_en   (hit),
                    .ld_data (ld_data),
                    .val     (grid[(gr*GC+gc)*DATA_W +: DATA_W]),
                    .ok      (ok_bits[(gr-1)*COLS+(gc-1)])
                );
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < GR; r++) begin
            for (int c = 0; c < GC; c++) begin
                if (rd_row == RIW'(r) && rd_col == CIW'(c))
                    rd_data = grid[(r*GC+c)*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/mesh_relax_chk.sv
module mesh_relax_chk
    import mesh_pkg::*;
#(
    parameter int MAX_ITER = 255,
    parameter int IW       = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          timeout,
    input logic [IW-1:0] iter_cnt,
    input op_e           op
);

    p_seq_down_up_r8: assert property (@(posedge clk) disable iff (rst)
        op == OP_MOVE_DOWN |=> op == OP_MOVE_UP);
    p_seq_left_avg_r8: assert property (@(posedge clk) disable iff (rst)
        op == OP_MOVE_LEFT |=> op == OP_AVG);
    p_seq_avg_commit_r8: assert property (@(posedge clk) disable iff (rst)
        op == OP_AVG |=> op == OP_COMMIT);
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        op == OP_COMMIT |=> iter_cnt == IW'($past(iter_cnt) + 1'b1));
    p_iter_cap_r7: assert property (@(posedge clk) disable iff (rst)
        int'(iter_cnt) <= MAX_ITER);
    p_timeout_done_r7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done);
    p_done_from_eval_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(op) == OP_EVAL);
    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done && !timeout && iter_cnt == '0));
    p_busy_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && op != OP_EVAL) |=> busy);

endmodule

bind mesh_relax mesh_relax_chk #(.MAX_ITER(MAX_ITER), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .timeout  (timeout),
    .iter_cnt (iter_cnt),
    .op       (op_w)
);

// File: tb/mesh_relax_tb.sv
module mesh_relax_tb;

    localparam int ROWS     = 4;
    localparam int COLS     = 4;
    localparam int MAX_ITER = 255;
    localparam int GR       = ROWS + 2;
    localparam int GC       = COLS + 2;
    localparam int RIW      = $clog2(GR);
    localparam int CIW      = $clog2(GC);
    localparam int IW       = $clog2(MAX_ITER + 1);
    localparam int NCASE    = 5;

    // fields: top, bottom, left, right, interior base, interior step, tol
    localparam logic [111:0] CASES [NCASE] = '{
        {16'd1000,  16'd1000,  16'd1000,  16'd1000,  16'd1000, 16'd0,    16'd1},
        {16'd4000,  16'd0,     16'd0,     16'd0,     16'd0,    16'd0,    16'd8},
        {16'd60000, 16'd100,   16'd3000,  16'd20000, 16'd500,  16'd3001, 16'd16},
        {16'd800,   16'd200,   16'd500,   16'd500,   16'd0,    16'd7,    16'd0},
        {16'd65535, 16'd65535, 16'd65535, 16'd65535, 16'd0,    16'd1000, 16'd2}
    };

    logic clk = 0;
    logic rst = 1;
    logic start = 0;
    logic [15:0] tol = 0;
    logic ld_en = 0;
    logic [RIW-1:0] ld_row = 0;
    logic [CIW-1:0] ld_col = 0;
    logic [15:0] ld_data = 0;
    logic [RIW-1:0] rd_row = 0;
    logic [CIW-1:0] rd_col = 0;
    logic [15:0] rd_data;
    logic busy, done, timeout;
    logic [IW-1:0] iter_cnt;

    int errors = 0;
    int checks = 0;
    int mdl [GR][GC];
    int exp_iter;
    bit exp_to;

    always #2.5 clk = ~clk;

    mesh_relax #(.ROWS(ROWS), .COLS(COLS), .MAX_ITER(MAX_ITER)) u_dut (
        .clk(clk), .rst(rst), .start(start), .tol(tol),
        .ld_en(ld_en), .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
        .busy(busy), .done(done), .timeout(timeout), .iter_cnt(iter_cnt)
    );

    task automatic check(input bit cond, input string tag, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic read_cell(input int r, input int c, output int v);
        rd_row = RIW'(r);
        rd_col = CIW'(c);
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic write_cell(input int r, input int c, input int v);
        ld_en = 1; ld_row = RIW'(r); ld_col = CIW'(c); ld_data = 16'(v);
        @(posedge clk); @(negedge clk);
        ld_en = 0;
    endtask

    task automatic load_case(input logic [111:0] e);
        for (int r = 0; r < GR; r++) begin
            for (int c = 0; c < GC; c++) begin
                int v;
                if (r == 0)            v = int'(e[111:96]);
                else if (r == GR - 1)  v = int'(e[95:80]);
                else if (c == 0)       v = int'(e[79:64]);
                else if (c == GC - 1)  v = int'(e[63:48]);
                else v = int'(16'(e[47:32] + e[31:16] * 16'(r * COLS + c)));
                mdl[r][c] = v;
                write_cell(r, c, v);
            end
        end
    endtask

    // Jacobi model: all new values from the previous iteration, then commit.
    task automatic run_model(input int t);
        int nx [GR][GC];
        bit all_ok;
        all_ok = 0;
        exp_iter = 0;
        while (!all_ok && exp_iter < MAX_ITER) begin
            all_ok = 1;
            nx = mdl;
            for (int r = 1; r <= ROWS; r++)
                for (int c = 1; c <= COLS; c++) begin
                    int d;
                    nx[r][c] = (mdl[r-1][c] + mdl[r+1][c] + mdl[r][c-1] + mdl[r][c+1]) >> 2;
                    d = nx[r][c] - mdl[r][c];
                    if (d < 0) d = -d;
                    if (d >= t) all_ok = 0;
                end
            mdl = nx;
            exp_iter++;
        end
        exp_to = !all_ok;
    endtask

    task automatic run_dut(input int t, input bit inject, output int n);
        tol = 16'(t);
        start = 1;
        @(posedge clk); @(negedge clk);
        start = 0;
        n = 0;
        while (n < 7 * MAX_ITER + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (inject && n == 10) begin
                // R9: mid-run load into interior and ring, plus a second start
                start = 1; ld_en = 1; ld_row = 1; ld_col = 1; ld_data = 16'd12345;
            end else if (inject && n == 11) begin
                start = 0; ld_row = 0; ld_col = 1; ld_data = 16'd9;
            end else if (inject && n == 12) begin
                ld_en = 0;
            end
            if (done) break;
        end
    endtask

    task automatic check_result(input string tag, input int n);
        int v;
        check(done == 1'b1, {tag, " R5 done"}, int'(done), 1);
        check(int'(iter_cnt) == exp_iter, {tag, " R6 iter_cnt"}, int'(iter_cnt), exp_iter);
        check(timeout == exp_to, {tag, " R7 timeout"}, int'(timeout), int'(exp_to));
        check(n == 7 * exp_iter, {tag, " R8 cycles"}, n, 7 * exp_iter);
        for (int r = 0; r < GR; r++)
            for (int c = 0; c < GC; c++) begin
                read_cell(r, c, v);
                if (r == 0 || r == GR - 1 || c == 0 || c == GC - 1)
                    check(v == mdl[r][c], $sformatf("%s R4 ring(%0d,%0d)", tag, r, c), v, mdl[r][c]);
                else
                    check(v == mdl[r][c], $sformatf("%s R3 cell(%0d,%0d)", tag, r, c), v, mdl[r][c]);
            end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, n;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check(busy == 0 && done == 0 && timeout == 0, "R1 flags", int'({busy, done, timeout}), 0);
        check(iter_cnt == 0, "R1 iter_cnt", int'(iter_cnt), 0);
        read_cell(0, 0, v);   check(v == 0, "R1 ring cell", v, 0);
        read_cell(2, 3, v);   check(v == 0, "R1 interior cell", v, 0);

        // R2: load and read back, out-of-range read
        write_cell(2, 3, 777);
        read_cell(2, 3, v);   check(v == 777, "R2 interior readback", v, 777);
        write_cell(5, 0, 4242);
        read_cell(5, 0, v);   check(v == 4242, "R2 corner readback", v, 4242);
        read_cell(7, 7, v);   check(v == 0, "R2 out of range", v, 0);

        // Table walk: R3..R8
        for (int k = 0; k < NCASE; k++) begin
            load_case(CASES[k]);
            run_model(int'(CASES[k][15:0]));
            run_dut(int'(CASES[k][15:0]), 1'b0, n);
            check_result($sformatf("case%0d", k), n);
        end

        // R9: loads and start during a run are ignored
        load_case(CASES[2]);
        run_model(int'(CASES[2][15:0]));
        run_dut(int'(CASES[2][15:0]), 1'b1, n);
        check_result("R9 inject", n);

        // R10: done holds, then a new start clears it
        repeat (5) @(negedge clk);
        check(done == 1 && busy == 0, "R10 done held", int'(done), 1);
        check(int'(iter_cnt) == exp_iter, "R10 iter held", int'(iter_cnt), exp_iter);
        load_case(CASES[3]);
        tol = 0;
        start = 1;
        @(posedge clk); @(negedge clk);
        start = 0;
        check(busy == 1 && done == 0, "R10 start clears done", int'({busy, done}), 2);
        check(timeout == 0 && iter_cnt == 0, "R10 start clears timeout/iter",
              int'(iter_cnt), 0);
        while (!done) @(negedge clk);
        check(timeout == 1 && int'(iter_cnt) == MAX_ITER, "R7 limit rerun",
              int'(iter_cnt), MAX_ITER);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule